// File: doc/BRIEF.md
# Oversampling Converter Bit-Clock Generator

This block derives the output bit clock of an oversampling audio converter from its master clock. The master clock is either 384 or 256 times the output word rate, and a mode input selects divide-by-3 or divide-by-2 so that the bit clock always runs at 128 times the word rate. A word-rate strobe marks the first bit-clock period of every frame of 128 periods.

The divider phase follows the left/right word-select input. After reset or power-down, the block stays idle and not ready until it sees the first synchronised rising edge of left/right. Where that edge falls, measured against the first master edge after release, decides whether the bit clock starts at once or one bit period later. Every later rising edge restarts the divider and the frame count at phase zero. The mode input is latched only at such an edge.

All state is cleared synchronously by the active-low reset. The active-low power-down input clears the same state when it is sampled low.

Top module: `os_bitclk_gen`

## Requirements
- R1: While `rst_n_i` is sampled low, `bclk_o`, `word_stb_o` and `ready_o` are 0 after that edge.
- R2: With a latched mode of 1, `bclk_o` repeats high for two master cycles and then low for one, starting high at each start of period.
- R3: With a latched mode of 0, `bclk_o` alternates high and low for one master cycle each, starting high.
- R4: An edge that samples `pwr_n_i` low drives all three outputs to 0 from that edge on. A left/right rise that falls within power-down has no effect.
- R5: Edge 0 is the first edge that samples both `rst_n_i` and `pwr_n_i` high. From edge 0 the outputs stay 0 until a left/right rise is acted on. A level first sampled high at edge k, after being low for at least three edges, is acted on at edge k+2.
- R6: If k < 2, `ready_o` and `bclk_o` both go high at edge k+2.
- R7: If k >= 2, `ready_o` goes high at edge k+2. `bclk_o` stays low for N more master cycles and rises at edge k+2+N, where N is 3 for mode 1 and 2 for mode 0, taken at edge k+2.
- R8: `word_stb_o` is high for exactly one master cycle. It pulses together with the first high cycle of `bclk_o` after an alignment and then every 128 bit periods. That spacing is 384 master cycles in mode 1 (12.288 MHz at 32 kHz) and 256 in mode 0 (11.2896 MHz at 44.1 kHz).
- R9: A change of `mode_fast_i` has no effect until the next left/right rise is acted on, and it is latched at that edge.
- R10: A left/right rise acted on while running restarts the bit clock high at that edge, with a strobe, and restarts the frame count from there. If it falls on a frame boundary, only one strobe is produced.
- R11: `ready_o` stays high across later realignments until reset or power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| mode_fast_i | input | 1 | 1: divide by 3 (384x), 0: divide by 2 (256x) |
| pwr_n_i | input | 1 | Active-low power-down, sampled on the master clock |
| lr_i | input | 1 | Left/right word select, asynchronous |
| bclk_o | output | 1 | Divided bit clock, 128x word rate |
| word_stb_o | output | 1 | One-cycle strobe at the start of each frame |
| ready_o | output | 1 | High once the divider has been aligned |

## Verification
The frame strobe that the period count produces and the strobe that a realignment produces can fall on the same master edge. The bench drops left/right and raises it again so that the rise is acted on exactly on the edge where the 128th divide-by-2 period would begin. It then expects one strobe there and the next one 256 cycles later. A second rise is acted on one cycle off that grid, and the bench expects the strobe and the bit-clock phase to move to the new origin and the old grid to disappear.

// File: rtl/bclkgen_pkg.sv
// Shared types and helpers for the bit-clock generator.
// Assumes divide ratios of at least 2.
package bclkgen_pkg;

    // Alignment state: waiting for left/right, holding off one period, running
    typedef enum logic [1:0] {
        AL_IDLE = 2'd0,
        AL_HOLD = 2'd1,
        AL_RUN  = 2'd2
    } align_st_t;

    // Number of master cycles the bit clock is high within one period
    function automatic int high_len(input int div);
        return div - div / 2;
    endfunction

endpackage

// File: rtl/bg_lr_sync.sv
// Left/right synchroniser and rising-edge detector.
// A level first sampled at edge k yields rise_o, which is acted on at edge k+STAGES.
// Assumes lr_i is asynchronous to clk_i; cleared only by the true reset.
module bg_lr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic lr_i,
    output logic rise_o
);
    logic [STAGES:0] shf_q;

    // Shift the asynchronous level through the synchroniser and one history flop
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) shf_q <= '0;
        else          shf_q <= {shf_q[STAGES-1:0], lr_i};
    end

    // A rise is a synchronised high whose previous value was low
    assign rise_o = shf_q[STAGES-1] & ~shf_q[STAGES];

endmodule

// File: rtl/bg_align_ctl.sv
// Alignment controller: counts master edges from release, sorts the first
// left/right rise into the early or late window, and issues divider restarts.
// Assumes clr_n_i = reset AND power-down release (both synchronous, active low).
module bg_align_ctl
    import bclkgen_pkg::*;
#(
    parameter int DIV_FAST   = 3,
    parameter int DIV_SLOW   = 2,
    parameter int EARLY_EDGE = 4
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic clr_n_i,
    input  logic rise_i,
    input  logic mode_i,
    output logic start_o,
    output logic run_o,
    output logic sel_o,
    output logic ready_o
);
    localparam int HC_W = $clog2(DIV_FAST);
    localparam int SR_W = $clog2(EARLY_EDGE + 1);
    localparam logic [HC_W-1:0] HOLD_F = HC_W'(DIV_FAST - 1);
    localparam logic [HC_W-1:0] HOLD_S = HC_W'(DIV_SLOW - 1);
    localparam logic [SR_W-1:0] SR_MAX = SR_W'(EARLY_EDGE);

    align_st_t       st_q, st_d;
    logic [HC_W-1:0] hold_q, hold_d;
    logic [SR_W-1:0] since_q;
    logic            early;

    assign early = since_q < SR_MAX;
    assign run_o = (st_q == AL_RUN);

    // Next-state decision for the alignment sequence
    always_comb begin
        st_d    = st_q;
        hold_d  = hold_q;
        start_o = 1'b0;
        case (st_q)
            AL_IDLE: begin
                if (rise_i) begin
                    if (early) begin
                        st_d    = AL_RUN;
                        start_o = 1'b1;
                    end else begin
                        st_d   = AL_HOLD;
                        hold_d = mode_i ? HOLD_F : HOLD_S;
                    end
                end
            end
            AL_HOLD: begin
                if (rise_i || hold_q == '0) begin
                    st_d    = AL_RUN;
                    start_o = 1'b1;
                end else begin
                    hold_d = hold_q - 1'b1;
                end
            end
            AL_RUN: begin
                if (rise_i) start_o = 1'b1;
            end
            default: st_d = AL_IDLE;
        endcase
    end

    // State, hold-off count and ready flag, cleared by reset or power-down
    always_ff @(posedge clk_i) begin
        if (!clr_n_i) begin
            st_q    <= AL_IDLE;
            hold_q  <= '0;
            ready_o <= 1'b0;
        end else begin
            st_q   <= st_d;
            hold_q <= hold_d;
            if (rise_i) ready_o <= 1'b1;
        end
    end

    // Saturating count of master edges since release
    always_ff @(posedge clk_i) begin
        if (!clr_n_i)              since_q <= '0;
        else if (since_q != SR_MAX) since_q <= since_q + 1'b1;
    end

    // Mode latch, loaded only on an accepted left/right rise
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)                sel_o <= 1'b0;
        else if (clr_n_i && rise_i)  sel_o <= mode_i;
    end

    // R5
    ready_rise_chk: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        $rose(ready_o) |-> $past(rise_i));

    // R9
    mode_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !$stable(sel_o) |-> $past(rise_i));

endmodule

// File: rtl/bg_phase_div.sv
// Phase divider: counts master cycles within one bit period and forms the
// registered bit clock; a start forces phase 0 with the clock high.
// Assumes sel_i changes only together with start_i.
module bg_phase_div
    import bclkgen_pkg::*;
#(
    parameter int DIV_FAST = 3,
    parameter int DIV_SLOW = 2
) (
    input  logic clk_i,
    input  logic clr_n_i,
    input  logic start_i,
    input  logic run_i,
    input  logic sel_i,
    output logic bclk_o,
    output logic wrap_o
);
    localparam int PH_W = $clog2(DIV_FAST);
    localparam logic [PH_W-1:0] LAST_F = PH_W'(DIV_FAST - 1);
    localparam logic [PH_W-1:0] LAST_S = PH_W'(DIV_SLOW - 1);
    localparam logic [PH_W-1:0] HI_F   = PH_W'(high_len(DIV_FAST));
    localparam logic [PH_W-1:0] HI_S   = PH_W'(high_len(DIV_SLOW));

    logic [PH_W-1:0] ph_q, ph_nx, last_ph, hi_ph;

    assign last_ph = sel_i ? LAST_F : LAST_S;
    assign hi_ph   = sel_i ? HI_F   : HI_S;
    assign ph_nx   = (ph_q == last_ph) ? '0 : ph_q + 1'b1;
    assign wrap_o  = run_i && !start_i && (ph_q == last_ph);

    // Phase counter and registered clock level
    always_ff @(posedge clk_i) begin
        if (!clr_n_i) begin
            ph_q   <= '0;
            bclk_o <= 1'b0;
        end else if (start_i) begin
            ph_q   <= '0;
            bclk_o <= 1'b1;
        end else if (run_i) begin
            ph_q   <= ph_nx;
            bclk_o <= (ph_nx < hi_ph);
        end else begin
            ph_q   <= '0;
            bclk_o <= 1'b0;
        end
    end

    // R2
    period_start_chk: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        wrap_o |=> bclk_o);

    // R3
    last_phase_low_chk: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        (run_i && !start_i && ph_q == last_ph) |-> !bclk_o);

endmodule

// File: rtl/bg_frame_count.sv
// Frame counter: counts bit periods and pulses a one-cycle strobe at each
// alignment start and at every FRAME_PERIODS-th period after it.
// Assumes wrap_i marks the master edge that begins a new bit period.
module bg_frame_count #(
    parameter int FRAME_PERIODS = 128
) (
    input  logic clk_i,
    input  logic clr_n_i,
    input  logic start_i,
    input  logic wrap_i,
    output logic stb_o
);
    localparam int PC_W = $clog2(FRAME_PERIODS);
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(FRAME_PERIODS - 1);

    logic [PC_W-1:0] pc_q;
    logic            frame_end;

    assign frame_end = wrap_i && (pc_q == PC_LAST);

    // Period count and strobe register
    always_ff @(posedge clk_i) begin
        if (!clr_n_i) begin
            pc_q  <= '0;
            stb_o <= 1'b0;
        end else begin
            stb_o <= start_i || frame_end;
            if (start_i)     pc_q <= '0;
            else if (wrap_i) pc_q <= frame_end ? '0 : pc_q + 1'b1;
        end
    end

    // R8
    single_strobe_chk: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        stb_o |=> !stb_o);

endmodule

// File: rtl/os_bitclk_gen.sv
// Top of the bit-clock generator: joins the left/right synchroniser, the
// alignment controller, the phase divider and the frame counter.
// Assumes clk_i is the master clock at 384x or 256x the word rate.
module os_bitclk_gen #(
    parameter int DIV_FAST      = 3,
    parameter int DIV_SLOW      = 2,
    parameter int FRAME_PERIODS = 128,
    parameter int SYNC_STAGES   = 2,
    parameter int EARLY_LIMIT   = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic mode_fast_i,
    input  logic pwr_n_i,
    input  logic lr_i,
    output logic bclk_o,
    output logic word_stb_o,
    output logic ready_o
);
    localparam int EARLY_EDGE = EARLY_LIMIT + SYNC_STAGES;

    logic clr_n, rise, start, run, sel, wrap;

    assign clr_n = rst_n_i & pwr_n_i;

    bg_lr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .lr_i    (lr_i),
        .rise_o  (rise)
    );

    bg_align_ctl #(
        .DIV_FAST   (DIV_FAST),
        .DIV_SLOW   (DIV_SLOW),
        .EARLY_EDGE (EARLY_EDGE)
    ) u_align (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .clr_n_i (clr_n),
        .rise_i  (rise),
        .mode_i  (mode_fast_i),
        .start_o (start),
        .run_o   (run),
        .sel_o   (sel),
        .ready_o (ready_o)
    );

    bg_phase_div #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW)
    ) u_div (
        .clk_i   (clk_i),
        .clr_n_i (clr_n),
        .start_i (start),
        .run_i   (run),
        .sel_i   (sel),
        .bclk_o  (bclk_o),
        .wrap_o  (wrap)
    );

    bg_frame_count #(.FRAME_PERIODS(FRAME_PERIODS)) u_frame (
        .clk_i   (clk_i),
        .clr_n_i (clr_n),
        .start_i (start),
        .wrap_i  (wrap),
        .stb_o   (word_stb_o)
    );

    // R4
    powerdown_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !pwr_n_i |=> (!bclk_o && !ready_o && !word_stb_o));

    // R8
    strobe_on_high_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        word_stb_o |-> bclk_o);

endmodule

// File: tb/tb_os_bitclk_gen.sv
module tb_os_bitclk_gen;

    logic clk = 1'b0;
    logic rst_n, mode_fast, pwr_n, lr;
    logic bclk, stb, rdy;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    typedef struct {
        bit    b;
        bit    s;
        bit    r;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    os_bitclk_gen dut (
        .clk_i       (clk),
        .rst_n_i     (rst_n),
        .mode_fast_i (mode_fast),
        .pwr_n_i     (pwr_n),
        .lr_i        (lr),
        .bclk_o      (bclk),
        .word_stb_o  (stb),
        .ready_o     (rdy)
    );

    // Driver side: one expected item per coming posedge, pushed at the negedge
    task automatic push_item(input bit b, input bit s, input bit r, input string tag);
        exp_t e;
        e.b = b; e.s = s; e.r = r; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic push_idle(input int n, input bit r, input string tag);
        for (int i = 0; i < n; i++) push_item(1'b0, 1'b0, r, tag);
    endtask

    // Running pattern: period index j counted from the last alignment start
    task automatic push_run(input int div, input int j0, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            int j;
            j = j0 + i;
            push_item((j % div) < (div - div / 2), (j % (div * 128)) == 0, 1'b1, tag);
        end
    endtask

    // Monitor: pop and compare one item just after each posedge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (bclk !== e.b || stb !== e.s || rdy !== e.r) begin
                    n_fails++;
                    $display("FAIL %s: got bclk=%0b stb=%0b ready=%0b expected bclk=%0b stb=%0b ready=%0b",
                             e.tag, bclk, stb, rdy, e.b, e.s, e.r);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got no end of run expected end of run");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pwr_n = 1'b1; lr = 1'b0; mode_fast = 1'b1;
        @(negedge clk);
        // R1 reset state
        push_idle(4, 1'b0, "R1");
        rst_n = 1'b1; pwr_n = 1'b0;
        push_idle(4, 1'b0, "R4");

        // R6 early: level sampled at edge 0, divide by 3, ratio 384 (R8)
        pwr_n = 1'b1; lr = 1'b1;
        push_idle(2, 1'b0, "R5 R6");
        push_run(3, 0, 400, "R2 R6 R8");

        // R9: mode change alone has no effect
        mode_fast = 1'b0;
        push_run(3, 400, 20, "R9 R2");
        lr = 1'b0;
        push_run(3, 420, 4, "R9 R2");
        lr = 1'b1;
        push_run(3, 424, 2, "R9 R2");
        // R10 realignment latches divide by 2, ratio 256 (R8)
        push_run(2, 0, 250, "R10 R3 R8 R11");

        // R10 realignment acted on a frame boundary: one strobe only
        lr = 1'b0;
        push_run(2, 250, 4, "R3");
        lr = 1'b1;
        push_run(2, 254, 270, "R10 R8 R11");
        // R10 realignment off the grid moves phase and frame origin
        lr = 1'b0;
        push_run(2, 524, 5, "R3");
        lr = 1'b1;
        push_run(2, 529, 2, "R3");
        push_run(2, 0, 260, "R10 R8 R11");

        // R4 power-down mid-run; left/right rise during it is ignored
        pwr_n = 1'b0;
        push_idle(5, 1'b0, "R4");
        lr = 1'b0;
        push_idle(3, 1'b0, "R4");
        lr = 1'b1;
        push_idle(5, 1'b0, "R4");
        // R5 release with left/right already high: stays idle
        pwr_n = 1'b1; mode_fast = 1'b1;
        push_idle(8, 1'b0, "R5");
        lr = 1'b0;
        push_idle(4, 1'b0, "R5");
        // R7 late: sampled at edge 12, divide by 3 hold-off
        lr = 1'b1;
        push_idle(2, 1'b0, "R5");
        push_idle(3, 1'b1, "R7");
        push_run(3, 0, 40, "R7 R2 R8");

        // R6 boundary: level sampled at edge 1 is early
        pwr_n = 1'b0; lr = 1'b0;
        push_idle(4, 1'b0, "R4");
        pwr_n = 1'b1;
        push_idle(1, 1'b0, "R5");
        lr = 1'b1;
        push_idle(2, 1'b0, "R6");
        push_run(3, 0, 10, "R6 R2");

        // R7 boundary: level sampled at edge 2 is late, divide by 2
        pwr_n = 1'b0; lr = 1'b0; mode_fast = 1'b0;
        push_idle(4, 1'b0, "R4");
        pwr_n = 1'b1;
        push_idle(2, 1'b0, "R5");
        lr = 1'b1;
        push_idle(2, 1'b0, "R7");
        push_idle(2, 1'b1, "R7");
        push_run(2, 0, 300, "R7 R3 R8");

        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule